// File: doc/BRIEF.md
# Cross trigger routing matrix

This block is a debug cross-trigger unit that is driven over a memory-mapped register port. Trigger input lines from debug sources are gathered onto a small set of broadcast channels. Each channel is then fanned back out to trigger output lines. Every trigger input has its own word holding the set of channels it feeds, and every trigger output has its own word holding the set of channels that may fire it. Software can also drive channels directly: it can hold a channel high, release it, or raise it for a single clock cycle. Trigger outputs are sticky. Once fired, an output stays high until software acknowledges it, so a short event on a channel is never lost to a slow consumer.

A key-protected lock guards the register port. After reset the unit is locked, and only the lock-access word accepts writes. Writing the unlock key opens the unit, and writing any other value to that word closes it again. Status words report the live trigger inputs, the latched trigger outputs, the channel inputs and the channel outputs. A block of fixed identification words sits at the top of the 4 KiB window.

The bus is a simple single-cycle port. A write takes effect at the clock edge where `bus_valid` and `bus_write` are both high. Read data is a combinational function of `bus_addr`.

Top module: `xtrig_matrix`

## Requirements
- R1: After reset the unit is locked and the lock-status word (offset 0xFB4) reads 1 in bit 0. The control word reads 0, all channel masks read 0 and `trig_out` is 0.
- R2: A write of 0xC5ACCE55 to offset 0xFB0 unlocks the unit, so that the lock-status word reads 0. A write of any other value to 0xFB0 locks it, so that the lock-status word reads 1. Writes to 0xFB0 are always accepted.
- R3: While the unit is locked, a write to any offset other than 0xFB0 leaves every register unchanged, as shown by readback.
- R4: Bit 0 of the control word at offset 0x000 is the global enable. While it is 0, every channel output is 0 and no trigger output is fired.
- R5: The word at offset 0x020+4*i is the channel mask of trigger input i, one bit per channel. Bit c of the channel-input status word (offset 0x138) is the OR, over every input i whose mask bit c is set, of `trig_in[i]`. This status is not gated by the enable.
- R6: The word at offset 0x0A0+4*j is the channel mask of trigger output j. `trig_out[j]` becomes 1 one clock after any channel selected in that mask is active at the channel outputs. An output whose mask selects no active channel stays 0.
- R7: A fired `trig_out[j]` stays 1 after its channels drop. Writing 1 to bit j of offset 0x010 clears it at that edge, unless a selected channel is still active at that edge, in which case the output stays 1.
- R8: A write to offset 0x014 sets the held software state of the channels whose data bits are 1. A write to offset 0x018 clears the held state of the channels whose data bits are 1. Offset 0x014 reads back the held state. Channel output c is the enable ANDed with (channel input c OR held state c OR pulse c).
- R9: A write to offset 0x01C makes each channel whose data bit is 1 active for exactly the one cycle that follows the write edge.
- R10: Offset 0x130 reads `trig_in`, 0x134 reads the latched `trig_out`, and 0x13C reads the channel outputs. Each value is right-aligned.
- R11: The identification words at offsets 0xFE0 to 0xFFC read 0x3C, 0xB7, 0x1A, 0x00, 0x0D, 0xF0, 0x05 and 0xB1 in address order. Any unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| trig_in | input | 8 | Trigger input lines |
| trig_out | output | 8 | Sticky trigger output lines |

## Verification
The bench targets three kinds of fault. The first is an acknowledge that races a channel that is still active: a design that lets the clear win would drop an output while its cause is still present. The second is a software pulse, which must be seen at the output latch but must be gone from channel status one cycle later: a design that holds it like a set would leave the channel stuck high. The third is write protection. The bench writes while locked, and again after relocking with a wrong key, so a decoder that ignores the lock, or one that treats any lock-word write as an unlock, shows changed readback. Disabling the unit while inputs stay mapped must silence the outputs but leave the channel-input status live.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
  localparam logic [31:0] UNLOCK_KEY = 32'hC5AC_CE55;

  // word indices (byte offset / 4)
  localparam int W_CTRL  = 0;
  localparam int W_ACK   = 4;
  localparam int W_SET   = 5;
  localparam int W_CLR   = 6;
  localparam int W_PULSE = 7;
  localparam int W_INMSK = 8;
  localparam int W_OUTMSK = 40;
  localparam int W_TINST = 76;
  localparam int W_TOUTST = 77;
  localparam int W_CHIST = 78;
  localparam int W_CHOST = 79;
  localparam int W_LOCK  = 1004;
  localparam int W_LSTAT = 1005;
  localparam int W_ID    = 1016;
  localparam int N_ID    = 8;

  function automatic logic [7:0] id_byte(input int k);
    case (k)
      0: id_byte = 8'h3C;
      1: id_byte = 8'hB7;
      2: id_byte = 8'h1A;
      3: id_byte = 8'h00;
      4: id_byte = 8'h0D;
      5: id_byte = 8'hF0;
      6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/xtrig_regbank.sv
module xtrig_regbank
  import xtrig_pkg::*;
#(
  parameter int N_TIN  = 8,
  parameter int N_TOUT = 8,
  parameter int N_CH   = 4,
  parameter int AW     = 12,
  parameter int DW     = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_valid,
  input  logic                           bus_write,
  input  logic [AW-1:0]                  bus_addr,
  input  logic [DW-1:0]                  bus_wdata,
  output logic                           locked,
  output logic                           en,
  output logic [N_TIN-1:0][N_CH-1:0]     in_mask,
  output logic [N_TOUT-1:0][N_CH-1:0]    out_mask,
  output logic [N_CH-1:0]                app_state,
  output logic [N_CH-1:0]                pulse,
  output logic [N_TOUT-1:0]              ack_bits
);
  localparam int WW = AW - 2;

  logic [WW-1:0] widx;
  logic          wr_any, wr_ok;
  logic          wr_lock, wr_ctrl, wr_ack, wr_set, wr_clr, wr_pulse;
  logic [N_TIN-1:0]  wr_in;
  logic [N_TOUT-1:0] wr_out;

  logic              locked_q, locked_d;
  logic              en_q, en_d;
  logic [N_CH-1:0]   app_q, app_d;
  logic              app_we;
  logic [N_CH-1:0]   pulse_q, pulse_d;
  logic [N_TIN-1:0][N_CH-1:0]  in_q;
  logic [N_TOUT-1:0][N_CH-1:0] out_q;

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  // address decode
  assign widx     = bus_addr[AW-1:2];
  assign wr_any   = bus_valid && bus_write;
  assign wr_ok    = wr_any && !locked_q;
  assign wr_lock  = wr_any && (widx == WW'(W_LOCK));
  assign wr_ctrl  = wr_ok  && (widx == WW'(W_CTRL));
  assign wr_ack   = wr_ok  && (widx == WW'(W_ACK));
  assign wr_set   = wr_ok  && (widx == WW'(W_SET));
  assign wr_clr   = wr_ok  && (widx == WW'(W_CLR));
  assign wr_pulse = wr_ok  && (widx == WW'(W_PULSE));

  // next-state logic
  always_comb begin
    locked_d = locked_q;
    if (wr_lock) locked_d = (bus_wdata != UNLOCK_KEY);
    en_d = wr_ctrl ? bus_wdata[0] : en_q;
    app_d  = app_q;
    app_we = wr_set || wr_clr;
    if (wr_set) app_d = app_q | bus_wdata[N_CH-1:0];
    if (wr_clr) app_d = app_q & ~bus_wdata[N_CH-1:0];
    pulse_d = wr_pulse ? bus_wdata[N_CH-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b1;
      en_q     <= 1'b0;
      app_q    <= '0;
      pulse_q  <= '0;
    end else begin
      locked_q <= locked_d;
      en_q     <= en_d;
      if (app_we) app_q <= app_d;
      pulse_q  <= pulse_d;
    end
  end

  // per-line channel mask registers
  for (genvar i = 0; i < N_TIN; i++) begin : g_in
    assign wr_in[i] = wr_ok && (widx == WW'(W_INMSK + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        in_q[i] <= '0;
      else if (wr_in[i]) in_q[i] <= bus_wdata[N_CH-1:0];
    end
  end

  for (genvar j = 0; j < N_TOUT; j++) begin : g_out
    assign wr_out[j] = wr_ok && (widx == WW'(W_OUTMSK + j));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         out_q[j] <= '0;
      else if (wr_out[j]) out_q[j] <= bus_wdata[N_CH-1:0];
    end
  end

  assign locked    = locked_q;
  assign en        = en_q;
  assign in_mask   = in_q;
  assign out_mask  = out_q;
  assign app_state = app_q;
  assign pulse     = pulse_q;
  assign ack_bits  = wr_ack ? bus_wdata[N_TOUT-1:0] : '0;

  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && bus_wdata == UNLOCK_KEY) |=> !locked_q); // R2
  AST_BAD_KEY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && bus_wdata != UNLOCK_KEY) |=> locked_q); // R2
  AST_LOCKED_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && wr_any && widx == WW'(W_CTRL)) |=> $stable(en_q)); // R3
  AST_LOCKED_APP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !wr_lock) |=> $stable(app_q)); // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_pulse) |=> (pulse_q == '0)); // R9
endmodule

// File: rtl/xtrig_route.sv
module xtrig_route #(
  parameter int N_TIN  = 8,
  parameter int N_TOUT = 8,
  parameter int N_CH   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic [N_TIN-1:0]            trig_in,
  input  logic [N_TIN-1:0][N_CH-1:0]  in_mask,
  input  logic [N_TOUT-1:0][N_CH-1:0] out_mask,
  input  logic [N_CH-1:0]             app_state,
  input  logic [N_CH-1:0]             pulse,
  input  logic [N_TOUT-1:0]           ack_bits,
  output logic [N_CH-1:0]             ch_in,
  output logic [N_CH-1:0]             ch_out,
  output logic [N_TOUT-1:0]           trig_out
);
  logic [N_TOUT-1:0] hit;
  logic [N_TOUT-1:0] tout_q, tout_d;

  // gather: inputs onto channels
  always_comb begin
    ch_in = '0;
    for (int i = 0; i < N_TIN; i++) begin
      ch_in = ch_in | (in_mask[i] & {N_CH{trig_in[i]}});
    end
    ch_out = en ? (ch_in | app_state | pulse) : '0;
  end

  // scatter: channels onto outputs, sticky until acknowledged
  for (genvar j = 0; j < N_TOUT; j++) begin : g_hit
    assign hit[j] = |(ch_out & out_mask[j]);

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tout_q[j] && !ack_bits[j]) |=> tout_q[j]); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_bits[j] && !hit[j]) |=> !tout_q[j]); // R7
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!tout_q[j] && !hit[j]) |=> !tout_q[j]); // R6
    AST_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      hit[j] |=> tout_q[j]); // R6
  end

  always_comb begin
    tout_d = (tout_q & ~ack_bits) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tout_q <= '0;
    else        tout_q <= tout_d;
  end

  assign trig_out = tout_q;

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$past(en)) |-> (ch_out == '0 && hit == '0)); // R4
endmodule

// File: rtl/xtrig_readmux.sv
module xtrig_readmux
  import xtrig_pkg::*;
#(
  parameter int N_TIN  = 8,
  parameter int N_TOUT = 8,
  parameter int N_CH   = 4,
  parameter int AW     = 12,
  parameter int DW     = 32
) (
  input  logic [AW-3:0]               widx,
  input  logic                        locked,
  input  logic                        en,
  input  logic [N_TIN-1:0][N_CH-1:0]  in_mask,
  input  logic [N_TOUT-1:0][N_CH-1:0] out_mask,
  input  logic [N_CH-1:0]             app_state,
  input  logic [N_TIN-1:0]            trig_in,
  input  logic [N_TOUT-1:0]           trig_out,
  input  logic [N_CH-1:0]             ch_in,
  input  logic [N_CH-1:0]             ch_out,
  output logic [DW-1:0]               rdata
);
  localparam int WW = AW - 2;

  always_comb begin
    rdata = '0;
    case (widx)
      WW'(W_CTRL):   rdata[0] = en;
      WW'(W_SET):    rdata[N_CH-1:0] = app_state;
      WW'(W_TINST):  rdata[N_TIN-1:0] = trig_in;
      WW'(W_TOUTST): rdata[N_TOUT-1:0] = trig_out;
      WW'(W_CHIST):  rdata[N_CH-1:0] = ch_in;
      WW'(W_CHOST):  rdata[N_CH-1:0] = ch_out;
      WW'(W_LSTAT):  rdata[0] = locked;
      default:       rdata = '0;
    endcase
    for (int i = 0; i < N_TIN; i++) begin
      if (widx == WW'(W_INMSK + i)) rdata[N_CH-1:0] = in_mask[i];
    end
    for (int j = 0; j < N_TOUT; j++) begin
      if (widx == WW'(W_OUTMSK + j)) rdata[N_CH-1:0] = out_mask[j];
    end
    for (int k = 0; k < N_ID; k++) begin
      if (widx == WW'(W_ID + k)) rdata[7:0] = id_byte(k);
    end
  end
endmodule

// File: rtl/xtrig_matrix.sv
module xtrig_matrix #(
  parameter int N_TIN  = 8,
  parameter int N_TOUT = 8,
  parameter int N_CH   = 4,
  parameter int AW     = 12,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [N_TIN-1:0]  trig_in,
  output logic [N_TOUT-1:0] trig_out
);
  logic                        locked, en;
  logic [N_TIN-1:0][N_CH-1:0]  in_mask;
  logic [N_TOUT-1:0][N_CH-1:0] out_mask;
  logic [N_CH-1:0]             app_state, pulse, ch_in, ch_out;
  logic [N_TOUT-1:0]           ack_bits, tout;

  xtrig_regbank #(.N_TIN(N_TIN), .N_TOUT(N_TOUT), .N_CH(N_CH), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .locked(locked), .en(en),
    .in_mask(in_mask), .out_mask(out_mask), .app_state(app_state),
    .pulse(pulse), .ack_bits(ack_bits)
  );

  xtrig_route #(.N_TIN(N_TIN), .N_TOUT(N_TOUT), .N_CH(N_CH)) u_route (
    .clk(clk), .rst_n(rst_n), .en(en), .trig_in(trig_in), .in_mask(in_mask),
    .out_mask(out_mask), .app_state(app_state), .pulse(pulse),
    .ack_bits(ack_bits), .ch_in(ch_in), .ch_out(ch_out), .trig_out(tout)
  );

  xtrig_readmux #(.N_TIN(N_TIN), .N_TOUT(N_TOUT), .N_CH(N_CH), .AW(AW), .DW(DW)) u_rmux (
    .widx(bus_addr[AW-1:2]), .locked(locked), .en(en), .in_mask(in_mask),
    .out_mask(out_mask), .app_state(app_state), .trig_in(trig_in),
    .trig_out(tout), .ch_in(ch_in), .ch_out(ch_out), .rdata(bus_rdata)
  );

  assign trig_out = tout;
endmodule

// File: tb/xtrig_matrix_tb.sv
module xtrig_matrix_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  trig_in = '0;
  logic [7:0]  trig_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xtrig_matrix dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trig_in(trig_in), .trig_out(trig_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_write = 1'b1; bus_valid = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_write = 1'b0; bus_valid = 1'b1;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic wait_neg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 trig_out after reset", {24'h0, trig_out}, 32'h0);
    bus_rd(12'hFB4, d); chk("R1 lock status", d, 32'h1);
    bus_rd(12'h000, d); chk("R1 control", d, 32'h0);
    bus_rd(12'h02C, d); chk("R1 input mask 3", d, 32'h0);
  endtask

  task automatic t_locked_writes;
    logic [31:0] d;
    bus_wr(12'h000, 32'h1);
    bus_rd(12'h000, d); chk("R3 control held while locked", d, 32'h0);
    bus_wr(12'h02C, 32'h5);
    bus_rd(12'h02C, d); chk("R3 mask held while locked", d, 32'h0);
    bus_wr(12'h014, 32'hF);
    bus_rd(12'h014, d); chk("R3 app state held while locked", d, 32'h0);
  endtask

  task automatic t_unlock;
    logic [31:0] d;
    bus_wr(12'hFB0, 32'hC5ACCE55);
    bus_rd(12'hFB4, d); chk("R2 unlocked by key", d, 32'h0);
    bus_wr(12'h000, 32'h1);
    bus_rd(12'h000, d); chk("R4 enable readback", d, 32'h1);
  endtask

  task automatic t_route;
    logic [31:0] d;
    bus_wr(12'h02C, 32'h5);          // input 3 -> channels 0,2
    bus_wr(12'h0B8, 32'h4);          // output 6 <- channel 2
    bus_wr(12'h0A4, 32'h2);          // output 1 <- channel 1
    bus_rd(12'h02C, d); chk("R5 input mask readback", d, 32'h5);
    @(negedge clk); trig_in = 8'h08;
    #1 chk("R10 trig_out not yet latched", {24'h0, trig_out}, 32'h0);
    @(negedge clk);
    chk("R6 output 6 fired, output 1 idle", {24'h0, trig_out}, 32'h40);
    bus_rd(12'h138, d); chk("R5 channel inputs", d, 32'h5);
    bus_rd(12'h13C, d); chk("R10 channel outputs", d, 32'h5);
    bus_rd(12'h130, d); chk("R10 trigger input status", d, 32'h08);
    @(negedge clk); trig_in = 8'h00;
    wait_neg(3);
    chk("R7 output held after channel drops", {24'h0, trig_out}, 32'h40);
    bus_rd(12'h134, d); chk("R10 trigger output status", d, 32'h40);
    bus_wr(12'h010, 32'h40);
    chk("R7 ack clears output", {24'h0, trig_out}, 32'h0);
  endtask

  task automatic t_ack_race;
    @(negedge clk); trig_in = 8'h08;
    wait_neg(2);
    bus_wr(12'h010, 32'h40);
    chk("R7 ack loses to active channel", {24'h0, trig_out}, 32'h40);
    @(negedge clk); trig_in = 8'h00;
    bus_wr(12'h010, 32'hFF);
    chk("R7 ack after channel drop", {24'h0, trig_out}, 32'h0);
  endtask

  task automatic t_disable;
    logic [31:0] d;
    bus_wr(12'h000, 32'h0);
    @(negedge clk); trig_in = 8'h08;
    wait_neg(3);
    chk("R4 no output while disabled", {24'h0, trig_out}, 32'h0);
    bus_rd(12'h13C, d); chk("R4 channel outputs zero while disabled", d, 32'h0);
    bus_rd(12'h138, d); chk("R5 channel inputs ungated", d, 32'h5);
    @(negedge clk); trig_in = 8'h00;
    bus_wr(12'h000, 32'h1);
  endtask

  task automatic t_app;
    logic [31:0] d;
    bus_wr(12'h0A0, 32'h8);          // output 0 <- channel 3
    bus_wr(12'h014, 32'h8);
    bus_rd(12'h014, d); chk("R8 set readback", d, 32'h8);
    chk("R8 held channel fires output 0", {24'h0, trig_out}, 32'h01);
    bus_wr(12'h018, 32'h8);
    bus_rd(12'h014, d); chk("R8 clear readback", d, 32'h0);
    bus_wr(12'h010, 32'h01);
    chk("R8 output 0 clearable after release", {24'h0, trig_out}, 32'h0);
  endtask

  task automatic t_pulse;
    logic [31:0] d;
    @(negedge clk);
    bus_addr = 12'h01C; bus_wdata = 32'h4; bus_write = 1'b1; bus_valid = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    chk("R9 output not latched during pulse cycle", {24'h0, trig_out}, 32'h0);
    @(negedge clk);
    chk("R9 pulse latched on output 6", {24'h0, trig_out}, 32'h40);
    bus_rd(12'h13C, d); chk("R9 pulse gone after one cycle", d, 32'h0);
    bus_wr(12'h010, 32'h40);
    chk("R9 output clears, pulse not held", {24'h0, trig_out}, 32'h0);
  endtask

  task automatic t_relock;
    logic [31:0] d;
    bus_wr(12'hFB0, 32'h3A5331AA);
    bus_rd(12'hFB4, d); chk("R2 relocked by wrong key", d, 32'h1);
    bus_wr(12'h000, 32'h0);
    bus_rd(12'h000, d); chk("R3 control held after relock", d, 32'h1);
  endtask

  task automatic t_ids;
    logic [31:0] d;
    logic [7:0] exp_id [8];
    exp_id = '{8'h3C, 8'hB7, 8'h1A, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int k = 0; k < 8; k++) begin
      bus_rd(12'hFE0 + 12'(4*k), d);
      chk("R11 id word", d, {24'h0, exp_id[k]});
    end
    bus_rd(12'h200, d); chk("R11 unmapped reads zero", d, 32'h0);
    bus_rd(12'h0C0, d); chk("R11 past last output mask reads zero", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked_writes();
    t_unlock();
    t_route();
    t_ack_race();
    t_disable();
    t_app();
    t_pulse();
    t_relock();
    t_ids();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule